// File: doc/BRIEF.md
# Memory-Mapped Register Bank with Atomic Vector Commit

This block is a single-beat AXI4-Lite slave that sits between a processor and a piece of custom algorithm logic. Software controls the algorithm through scalar input registers. It also sets vector inputs whose elements are first written into staging registers. A write to that vector's commit register then copies every staged element into the shadow registers that drive the algorithm, all in one clock cycle. The algorithm therefore never sees a half-updated vector. In the other direction, scalar results are read live. A vector result is frozen by a write to its capture register, so that later reads of its elements return one coherent snapshot.

The read multiplexer is built as a chain of segments. A pipeline register can be placed after every `PIPE_RATIO` registers of the map, which shortens the logic path at the cost of read latency. `PIPE_RATIO` is 0, which gives one unbroken segment, or a value from 5 to 50. Readback of the software-written registers is a build option. Every storage register resets to a value given by a parameter, and that value defaults to zero.

All five AXI channels follow valid/ready rules. A source holds VALID and its payload until READY is seen at a clock edge. The slave drops AWREADY and WREADY while it holds a write address or write data, or while BVALID is pending. It drops ARREADY from the acceptance of a read until the R handshake completes. The slave therefore takes one read and one write at a time, and back-pressure on B or R stalls only that channel.

Top module: `regbank_lite`

## Requirements
- R1: After reset, every scalar input register, vector shadow register, vector staging register and vector snapshot register holds its parameter initial value. These values drive `scalar_in_o` and `vec_in_o` and are returned by reads. BVALID and RVALID are low.
- R2: Write address and write data are accepted in either order or in the same cycle. BVALID rises only after both have been accepted, with BRESP = 00, and stays high until BREADY.
- R3: Only the byte lanes whose WSTRB bit is 1 are updated in scalar input and staging registers. For example, WSTRB bit 0 covers data bits 7:0.
- R4: A write to scalar input word index i (0 to N_SCALAR_IN-1, byte address 4*i) appears on `scalar_in_o` slice i by the time BVALID is seen.
- R5: Writes to staging word indices N_SCALAR_IN to N_SCALAR_IN+VEC_IN_LEN-1 change neither `vec_in_o` nor the readback of those indices. Readback of these indices returns the shadow value. When the commit register (the next index) is written with bit 0 set under WSTRB bit 0, all staged elements reach `vec_in_o` in the same cycle.
- R6: The commit and capture registers always read 0. A write to either with data bit 0 clear has no effect.
- R7: Writing bit 0 = 1 to the capture register (the last index) copies `vec_out_i` into the snapshot indices, which follow the scalar output indices. Later changes on `vec_out_i` do not change what those indices read.
- R8: Reads of scalar output indices (after the commit register) return the live `scalar_out_i` slice.
- R9: With READBACK_EN = 0, scalar input and vector input indices read 0 while the outputs still take the written values.
- R10: A read at an index past the map returns 0 with RRESP = 00. A write there is acknowledged with BRESP = 00 and changes no register.
- R11: RVALID rises exactly NSEG cycles after the cycle in which ARVALID and ARREADY are both high, where NSEG = ceil(register count / PIPE_RATIO). RDATA and RVALID are held until RREADY.
- R12: With PIPE_RATIO = 0 the read latency is one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte enables |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response, always 00 |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always 00 |
| scalar_in_o | output | N_SCALAR_IN*DATA_W | Scalar input registers to the algorithm |
| vec_in_o | output | VEC_IN_LEN*DATA_W | Committed vector elements to the algorithm |
| scalar_out_i | input | N_SCALAR_OUT*DATA_W | Scalar results from the algorithm |
| vec_out_i | input | VEC_OUT_LEN*DATA_W | Vector result from the algorithm |

## Verification
Suppose a shadow register loaded early or a commit pulse failed to clear. `vec_in_o` would then differ from the last committed vector straight after the very next staging write, which the bench sees as soon as the B handshake returns. A wrong snapshot shows up on the first read of a snapshot index after `vec_out_i` moves, since the read returns the new value instead of the frozen one. A read pipeline stage that dropped its valid or took the wrong segment shows at the ports as a wrong latency count or wrong data on the same read. A lost pairing of address and data in the write path shows as a BVALID that comes early or never comes.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  // Map: scalar-in, staging, commit, scalar-out, snapshot, capture.
  function automatic int rb_reg_count(int nsi, int nvi, int nso, int nvo);
    return nsi + nvi + 1 + nso + nvo + 1;
  endfunction

  function automatic int rb_seg_size(int nreg, int ratio);
    return (ratio == 0) ? nreg : ratio;
  endfunction

  function automatic int rb_stage_count(int nreg, int ratio);
    int seg;
    seg = rb_seg_size(nreg, ratio);
    return (nreg + seg - 1) / seg;
  endfunction

endpackage

// File: rtl/rb_write_ctrl.sv
module rb_write_ctrl #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  localparam int NB    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  output logic              awready,
  input  logic [IDX_W-1:0]  aw_idx,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NB-1:0]     wstrb,
  output logic              bvalid,
  input  logic              bready,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic [NB-1:0]     wr_strb
);

  logic aw_have, w_have, bvalid_q;

  assign awready = !aw_have && !bvalid_q;
  assign wready  = !w_have  && !bvalid_q;
  assign bvalid  = bvalid_q;
  assign wr_en   = aw_have && w_have;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_have  <= 1'b0;
      w_have   <= 1'b0;
      bvalid_q <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      wr_strb  <= '0;
    end else begin
      if (awvalid && awready) begin
        aw_have <= 1'b1;
        wr_idx  <= aw_idx;
      end
      if (wvalid && wready) begin
        w_have  <= 1'b1;
        wr_data <= wdata;
        wr_strb <= wstrb;
      end
      if (wr_en) begin
        aw_have  <= 1'b0;
        w_have   <= 1'b0;
        bvalid_q <= 1'b1;
      end else if (bvalid_q && bready) begin
        bvalid_q <= 1'b0;
      end
    end
  end

  // R2: the response stays up until it is taken
  a_r2_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid);

  // R2: no new address is taken while a response is pending
  a_r2_no_aw_during_b: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> !(awvalid && awready));

endmodule

// File: rtl/rb_regs.sv
module rb_regs #(
  parameter int DATA_W       = 32,
  parameter int IDX_W        = 6,
  parameter int NSI          = 2,
  parameter int NVI          = 3,
  parameter int NSO          = 1,
  parameter int NVO          = 3,
  parameter bit READBACK_EN  = 1'b1,
  parameter logic [NSI*DATA_W-1:0] SIN_INIT  = '0,
  parameter logic [NVI*DATA_W-1:0] VIN_INIT  = '0,
  parameter logic [NVO*DATA_W-1:0] VOUT_INIT = '0,
  localparam int NB   = DATA_W / 8,
  localparam int NREG = regbank_pkg::rb_reg_count(NSI, NVI, NSO, NVO)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [NB-1:0]          wr_strb,
  output logic [NSI*DATA_W-1:0]  sin_o,
  output logic [NVI*DATA_W-1:0]  vin_o,
  input  logic [NSO*DATA_W-1:0]  sout_i,
  input  logic [NVO*DATA_W-1:0]  vout_i,
  output logic [NREG*DATA_W-1:0] rd_vec
);

  localparam int BASE_STG  = NSI;
  localparam int IDX_VCOM  = NSI + NVI;
  localparam int BASE_SOUT = IDX_VCOM + 1;
  localparam int BASE_SNAP = BASE_SOUT + NSO;
  localparam int IDX_OCAP  = BASE_SNAP + NVO;

  logic [DATA_W-1:0] sin_q  [NSI];
  logic [DATA_W-1:0] stg_q  [NVI];
  logic [DATA_W-1:0] shd_q  [NVI];
  logic [DATA_W-1:0] snap_q [NVO];
  logic              vcom_q, ocap_q;
  logic [NVO*DATA_W-1:0] snap_flat;

  wire commit_hit  = wr_en && (wr_idx == IDX_W'(IDX_VCOM)) && wr_strb[0] && wr_data[0];
  wire capture_hit = wr_en && (wr_idx == IDX_W'(IDX_OCAP)) && wr_strb[0] && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcom_q <= 1'b0;
      ocap_q <= 1'b0;
    end else begin
      vcom_q <= commit_hit;
      ocap_q <= capture_hit;
    end
  end

  genvar i;
  generate
    for (i = 0; i < NSI; i++) begin : g_sin
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sin_q[i] <= SIN_INIT[i*DATA_W +: DATA_W];
        else if (wr_en && wr_idx == IDX_W'(i)) begin
          for (int b = 0; b < NB; b++)
            if (wr_strb[b]) sin_q[i][b*8 +: 8] <= wr_data[b*8 +: 8];
        end
      end
      assign sin_o[i*DATA_W +: DATA_W] = sin_q[i];
      assign rd_vec[i*DATA_W +: DATA_W] = READBACK_EN ? sin_q[i] : '0;
    end

    for (i = 0; i < NVI; i++) begin : g_vin
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= VIN_INIT[i*DATA_W +: DATA_W];
        else if (wr_en && wr_idx == IDX_W'(BASE_STG + i)) begin
          for (int b = 0; b < NB; b++)
            if (wr_strb[b]) stg_q[i][b*8 +: 8] <= wr_data[b*8 +: 8];
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      shd_q[i] <= VIN_INIT[i*DATA_W +: DATA_W];
        else if (vcom_q) shd_q[i] <= stg_q[i];
      end
      assign vin_o[i*DATA_W +: DATA_W] = shd_q[i];
      assign rd_vec[(BASE_STG+i)*DATA_W +: DATA_W] = READBACK_EN ? shd_q[i] : '0;
    end

    for (i = 0; i < NSO; i++) begin : g_sout
      assign rd_vec[(BASE_SOUT+i)*DATA_W +: DATA_W] = sout_i[i*DATA_W +: DATA_W];
    end

    for (i = 0; i < NVO; i++) begin : g_snap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      snap_q[i] <= VOUT_INIT[i*DATA_W +: DATA_W];
        else if (ocap_q) snap_q[i] <= vout_i[i*DATA_W +: DATA_W];
      end
      assign snap_flat[i*DATA_W +: DATA_W] = snap_q[i];
      assign rd_vec[(BASE_SNAP+i)*DATA_W +: DATA_W] = snap_q[i];
    end
  endgenerate

  assign rd_vec[IDX_VCOM*DATA_W +: DATA_W] = '0;
  assign rd_vec[IDX_OCAP*DATA_W +: DATA_W] = '0;

  // R6: commit and capture pulses last one cycle
  a_r6_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    vcom_q |=> !vcom_q);
  a_r6_capture_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ocap_q |=> !ocap_q);

  // R5: the algorithm-side vector moves only on a commit
  a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vcom_q |=> $stable(vin_o));

  // R7: the snapshot moves only on a capture
  a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ocap_q |=> $stable(snap_flat));

endmodule

// File: rtl/rb_read_pipe.sv
module rb_read_pipe #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  parameter int NREG   = 11,
  parameter int RATIO  = 5,
  localparam int SEG   = regbank_pkg::rb_seg_size(NREG, RATIO),
  localparam int NSEG  = regbank_pkg::rb_stage_count(NREG, RATIO)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   arvalid,
  output logic                   arready,
  input  logic [IDX_W-1:0]       ar_idx,
  output logic                   rvalid,
  input  logic                   rready,
  output logic [DATA_W-1:0]      rdata,
  input  logic [NREG*DATA_W-1:0] rd_vec
);

  logic                busy;
  logic [IDX_W-1:0]    st_idx [NSEG];
  logic [DATA_W-1:0]   st_acc [NSEG];
  logic [NSEG-1:0]     st_v;
  logic [IDX_W-1:0]    in_idx [NSEG];
  logic [DATA_W-1:0]   in_acc [NSEG];
  logic [NSEG-1:0]     in_v;

  wire ar_hs = arvalid && arready;
  assign arready = !busy;
  assign rvalid  = st_v[NSEG-1];
  assign rdata   = st_acc[NSEG-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy <= 1'b0;
    else if (ar_hs)            busy <= 1'b1;
    else if (rvalid && rready) busy <= 1'b0;
  end

  genvar k;
  generate
    for (k = 0; k < NSEG; k++) begin : g_stage
      localparam int LO = k * SEG;
      localparam int HI = ((k + 1) * SEG > NREG) ? NREG : (k + 1) * SEG;
      logic [DATA_W-1:0] seg;

      if (k == 0) begin : g_head
        assign in_idx[k] = ar_idx;
        assign in_acc[k] = '0;
        assign in_v[k]   = ar_hs;
      end else begin : g_link
        assign in_idx[k] = st_idx[k-1];
        assign in_acc[k] = st_acc[k-1];
        assign in_v[k]   = st_v[k-1];
      end

      always_comb begin
        seg = in_acc[k];
        for (int j = LO; j < HI; j++)
          if (in_idx[k] == IDX_W'(j)) seg = rd_vec[j*DATA_W +: DATA_W];
      end

      if (k < NSEG - 1) begin : g_mid
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            st_v[k]   <= 1'b0;
            st_idx[k] <= '0;
            st_acc[k] <= '0;
          end else begin
            st_v[k] <= in_v[k];
            if (in_v[k]) begin
              st_idx[k] <= in_idx[k];
              st_acc[k] <= seg;
            end
          end
        end
      end else begin : g_last
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            st_v[k]   <= 1'b0;
            st_idx[k] <= '0;
            st_acc[k] <= '0;
          end else if (in_v[k]) begin
            st_v[k]   <= 1'b1;
            st_idx[k] <= in_idx[k];
            st_acc[k] <= seg;
          end else if (rready) begin
            st_v[k] <= 1'b0;
          end
        end
      end
    end
  endgenerate

  // R11: read data and valid are held under back-pressure
  a_r11_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata));

  // R11: no second read enters while a result is waiting
  a_r11_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> !ar_hs);

  // R11: at most one read is ever in flight in the chain
  a_r11_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(st_v));

endmodule

// File: rtl/regbank_lite.sv
module regbank_lite #(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 8,
  parameter int N_SCALAR_IN  = 2,
  parameter int VEC_IN_LEN   = 3,
  parameter int N_SCALAR_OUT = 1,
  parameter int VEC_OUT_LEN  = 3,
  parameter bit READBACK_EN  = 1'b1,
  parameter int PIPE_RATIO   = 5,
  parameter logic [N_SCALAR_IN*DATA_W-1:0] SIN_INIT  = '0,
  parameter logic [VEC_IN_LEN*DATA_W-1:0]  VIN_INIT  = '0,
  parameter logic [VEC_OUT_LEN*DATA_W-1:0] VOUT_INIT = '0,
  localparam int NB    = DATA_W / 8,
  localparam int IDX_W = ADDR_W - 2,
  localparam int NREG  = regbank_pkg::rb_reg_count(N_SCALAR_IN, VEC_IN_LEN,
                                                   N_SCALAR_OUT, VEC_OUT_LEN)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            s_awvalid,
  output logic                            s_awready,
  input  logic [ADDR_W-1:0]               s_awaddr,
  input  logic                            s_wvalid,
  output logic                            s_wready,
  input  logic [DATA_W-1:0]               s_wdata,
  input  logic [NB-1:0]                   s_wstrb,
  output logic                            s_bvalid,
  input  logic                            s_bready,
  output logic [1:0]                      s_bresp,
  input  logic                            s_arvalid,
  output logic                            s_arready,
  input  logic [ADDR_W-1:0]               s_araddr,
  output logic                            s_rvalid,
  input  logic                            s_rready,
  output logic [DATA_W-1:0]               s_rdata,
  output logic [1:0]                      s_rresp,
  output logic [N_SCALAR_IN*DATA_W-1:0]   scalar_in_o,
  output logic [VEC_IN_LEN*DATA_W-1:0]    vec_in_o,
  input  logic [N_SCALAR_OUT*DATA_W-1:0]  scalar_out_i,
  input  logic [VEC_OUT_LEN*DATA_W-1:0]   vec_out_i
);

  logic                   wr_en;
  logic [IDX_W-1:0]       wr_idx;
  logic [DATA_W-1:0]      wr_data;
  logic [NB-1:0]          wr_strb;
  logic [NREG*DATA_W-1:0] rd_vec;

  assign s_bresp = regbank_pkg::RESP_OKAY;
  assign s_rresp = regbank_pkg::RESP_OKAY;

  rb_write_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awvalid(s_awvalid), .awready(s_awready), .aw_idx(s_awaddr[ADDR_W-1:2]),
    .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata), .wstrb(s_wstrb),
    .bvalid(s_bvalid), .bready(s_bready),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb)
  );

  rb_regs #(
    .DATA_W(DATA_W), .IDX_W(IDX_W),
    .NSI(N_SCALAR_IN), .NVI(VEC_IN_LEN), .NSO(N_SCALAR_OUT), .NVO(VEC_OUT_LEN),
    .READBACK_EN(READBACK_EN),
    .SIN_INIT(SIN_INIT), .VIN_INIT(VIN_INIT), .VOUT_INIT(VOUT_INIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
    .sin_o(scalar_in_o), .vin_o(vec_in_o),
    .sout_i(scalar_out_i), .vout_i(vec_out_i),
    .rd_vec(rd_vec)
  );

  rb_read_pipe #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .NREG(NREG), .RATIO(PIPE_RATIO)
  ) u_rd (
    .clk(clk), .rst_n(rst_n),
    .arvalid(s_arvalid), .arready(s_arready), .ar_idx(s_araddr[ADDR_W-1:2]),
    .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata),
    .rd_vec(rd_vec)
  );

endmodule

// File: tb/regbank_lite_tb_top.sv
`timescale 1ns/1ps
module regbank_lite_tb_top;

  localparam int NREG   = 11;
  localparam int NSEG_A = (NREG + 5 - 1) / 5;
  localparam logic [63:0] SIN_I  = {32'h0000_00A5, 32'h1234_5678};
  localparam logic [95:0] VIN_I  = {32'h0000_0033, 32'h0000_0022, 32'h0000_0011};
  localparam logic [95:0] VOUT_I = {32'h0000_00C3, 32'h0000_00B2, 32'h0000_00A1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [7:0]  awaddr = 0, araddr = 0;
  logic [31:0] wdata = 0;
  logic [3:0]  wstrb = 0;
  logic [31:0] sout = 0;
  logic [95:0] vout = 0;
  bit          sel = 0;

  logic a_awready, a_wready, a_bvalid, a_arready, a_rvalid;
  logic b_awready, b_wready, b_bvalid, b_arready, b_rvalid;
  logic [1:0]  a_bresp, a_rresp, b_bresp, b_rresp;
  logic [31:0] a_rdata, b_rdata;
  logic [63:0] a_sin, b_sin;
  logic [95:0] a_vin, b_vin;

  regbank_lite #(.READBACK_EN(1'b1), .PIPE_RATIO(5),
    .SIN_INIT(SIN_I), .VIN_INIT(VIN_I), .VOUT_INIT(VOUT_I)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(awvalid && !sel), .s_awready(a_awready), .s_awaddr(awaddr),
    .s_wvalid(wvalid && !sel), .s_wready(a_wready), .s_wdata(wdata), .s_wstrb(wstrb),
    .s_bvalid(a_bvalid), .s_bready(bready && !sel), .s_bresp(a_bresp),
    .s_arvalid(arvalid && !sel), .s_arready(a_arready), .s_araddr(araddr),
    .s_rvalid(a_rvalid), .s_rready(rready && !sel), .s_rdata(a_rdata), .s_rresp(a_rresp),
    .scalar_in_o(a_sin), .vec_in_o(a_vin), .scalar_out_i(sout), .vec_out_i(vout));

  regbank_lite #(.READBACK_EN(1'b0), .PIPE_RATIO(0),
    .SIN_INIT(SIN_I), .VIN_INIT(VIN_I), .VOUT_INIT(VOUT_I)) dut_nrb (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(awvalid && sel), .s_awready(b_awready), .s_awaddr(awaddr),
    .s_wvalid(wvalid && sel), .s_wready(b_wready), .s_wdata(wdata), .s_wstrb(wstrb),
    .s_bvalid(b_bvalid), .s_bready(bready && sel), .s_bresp(b_bresp),
    .s_arvalid(arvalid && sel), .s_arready(b_arready), .s_araddr(araddr),
    .s_rvalid(b_rvalid), .s_rready(rready && sel), .s_rdata(b_rdata), .s_rresp(b_rresp),
    .scalar_in_o(b_sin), .vec_in_o(b_vin), .scalar_out_i(sout), .vec_out_i(vout));

  wire        awready = sel ? b_awready : a_awready;
  wire        wready  = sel ? b_wready  : a_wready;
  wire        bvalid  = sel ? b_bvalid  : a_bvalid;
  wire [1:0]  bresp   = sel ? b_bresp   : a_bresp;
  wire        arready = sel ? b_arready : a_arready;
  wire        rvalid  = sel ? b_rvalid  : a_rvalid;
  wire [31:0] rdata   = sel ? b_rdata   : a_rdata;
  wire [1:0]  rresp   = sel ? b_rresp   : a_rresp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_sin [2];
  logic [31:0] m_stg [3];
  logic [31:0] m_shd [3];
  logic [31:0] m_snap[3];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] s);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_read(int idx);
    if (idx < 2)  return m_sin[idx];
    if (idx < 5)  return m_shd[idx-2];
    if (idx == 6) return sout;
    if (idx >= 7 && idx < 10) return m_snap[idx-7];
    return 32'h0;
  endfunction

  task automatic model_write(int idx, logic [31:0] d, logic [3:0] s);
    if (idx < 2) m_sin[idx] = merge(m_sin[idx], d, s);
    else if (idx < 5) m_stg[idx-2] = merge(m_stg[idx-2], d, s);
    else if (idx == 5 && s[0] && d[0]) for (int e = 0; e < 3; e++) m_shd[e] = m_stg[e];
    else if (idx == 10 && s[0] && d[0]) for (int e = 0; e < 3; e++) m_snap[e] = vout[e*32 +: 32];
  endtask

  task automatic do_write(int idx, logic [31:0] d, logic [3:0] s, int mode);
    bit aw_done = 0, w_done = 0, aw_hit, w_hit;
    int dly;
    awaddr = 8'(idx * 4); wdata = d; wstrb = s;
    while (!(aw_done && w_done)) begin
      @(negedge clk);
      chk("R2 BVALID before both accepted", {31'b0, bvalid}, 32'd0);
      awvalid = !aw_done && (mode != 2 || w_done);
      wvalid  = !w_done  && (mode != 1 || aw_done);
      aw_hit = awvalid && awready;
      w_hit  = wvalid && wready;
      @(posedge clk);
      if (aw_hit) aw_done = 1;
      if (w_hit)  w_done = 1;
    end
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    while (!bvalid) @(negedge clk);
    chk("R2 BRESP", {30'b0, bresp}, 32'd0);
    dly = $urandom % 3;
    repeat (dly) begin
      @(negedge clk);
      chk("R2 BVALID held", {31'b0, bvalid}, 32'd1);
    end
    bready = 1;
    @(posedge clk);
    @(negedge clk);
    bready = 0;
    if (!sel) model_write(idx, d, s);
  endtask

  task automatic do_read(int idx, output logic [31:0] d);
    bit hit;
    int lat, dly, exp_lat;
    exp_lat = sel ? 1 : NSEG_A;
    @(negedge clk);
    araddr = 8'(idx * 4); arvalid = 1;
    forever begin
      hit = arready;
      @(posedge clk);
      if (hit) break;
      @(negedge clk);
    end
    @(negedge clk);
    arvalid = 0;
    lat = 1;
    while (!rvalid && lat < 50) begin @(negedge clk); lat++; end
    chk(sel ? "R12 read latency" : "R11 read latency", lat, exp_lat);
    d = rdata;
    chk("R10 RRESP", {30'b0, rresp}, 32'd0);
    dly = $urandom % 4;
    repeat (dly) begin
      @(negedge clk);
      chk("R11 RVALID held", {31'b0, rvalid}, 32'd1);
      chk("R11 RDATA held", rdata, d);
    end
    rready = 1;
    @(posedge clk);
    @(negedge clk);
    rready = 0;
  endtask

  task automatic check_outs(string req);
    for (int e = 0; e < 2; e++) chk(req, a_sin[e*32 +: 32], m_sin[e]);
    for (int e = 0; e < 3; e++) chk(req, a_vin[e*32 +: 32], m_shd[e]);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R11 watchdog expired actual=hang expected=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0042));
    m_sin[0] = SIN_I[31:0]; m_sin[1] = SIN_I[63:32];
    for (int e = 0; e < 3; e++) begin
      m_stg[e] = VIN_I[e*32 +: 32]; m_shd[e] = VIN_I[e*32 +: 32];
      m_snap[e] = VOUT_I[e*32 +: 32];
    end
    sout = 32'hDEAD_0001;
    vout = {32'h3333_0003, 32'h2222_0002, 32'h1111_0001};
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 BVALID at reset", {31'b0, a_bvalid}, 32'd0);
    chk("R1 RVALID at reset", {31'b0, a_rvalid}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check_outs("R1 outputs after reset");
    for (int i = 0; i < NREG; i++) begin
      do_read(i, d);
      chk("R1 reset readback", d, exp_read(i));
    end

    // R2: all three orderings
    for (int m = 0; m < 3; m++) begin
      do_write(1, 32'hA0B0_C000 + m, 4'hF, m);
      do_read(1, d);
      chk("R2 ordering write data", d, 32'hA0B0_C000 + m);
    end
    check_outs("R4 scalar output after write");

    // R3: byte lanes
    do_write(0, 32'hFFFF_FFFF, 4'b0101, 0);
    do_read(0, d);
    chk("R3 byte lanes", d, 32'h12FF_56FF);

    // R5/R6: staging and commit
    do_write(2, 32'h0000_0AAA, 4'hF, 1);
    do_write(3, 32'h0000_0BBB, 4'hF, 2);
    do_write(4, 32'h0000_0CCC, 4'hF, 0);
    check_outs("R5 staging not yet visible");
    do_read(3, d);
    chk("R5 readback shows shadow before commit", d, 32'h0000_0022);
    do_write(5, 32'hFFFF_FFFE, 4'hF, 0);
    check_outs("R6 commit with bit0 clear ignored");
    do_read(5, d);
    chk("R6 commit reads zero", d, 32'h0);
    do_write(5, 32'h1, 4'h1, 0);
    chk("R5 commit element 0", a_vin[31:0], 32'h0000_0AAA);
    chk("R5 commit element 2", a_vin[95:64], 32'h0000_0CCC);
    check_outs("R5 all elements after commit");

    // R7: capture then move the source
    do_write(10, 32'h1, 4'h1, 0);
    @(negedge clk);
    vout = {32'h9999_0009, 32'h8888_0008, 32'h7777_0007};
    do_read(8, d);
    chk("R7 snapshot coherent", d, 32'h2222_0002);
    do_read(10, d);
    chk("R6 capture reads zero", d, 32'h0);
    do_write(10, 32'h0, 4'hF, 0);
    do_read(9, d);
    chk("R6 capture with bit0 clear ignored", d, 32'h3333_0003);

    // R8: live scalar output
    sout = 32'h0BAD_CAFE;
    do_read(6, d);
    chk("R8 live scalar output", d, 32'h0BAD_CAFE);

    // R10: unmapped
    do_read(13, d);
    chk("R10 unmapped read", d, 32'h0);
    do_write(12, 32'h5555_5555, 4'hF, 0);
    for (int i = 0; i < NREG; i++) begin
      do_read(i, d);
      chk("R10 unmapped write ignored", d, exp_read(i));
    end
    check_outs("R10 outputs after unmapped write");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op, idx;
      op = $urandom % 4;
      if (op == 0) begin
        idx = $urandom % 13;
        do_write(idx, $urandom, 4'($urandom), $urandom % 3);
        @(negedge clk);
        check_outs("R5 random outputs");
      end else if (op == 3) begin
        @(negedge clk);
        sout = $urandom;
        vout = {$urandom, $urandom, $urandom};
      end else begin
        idx = $urandom % 14;
        do_read(idx, d);
        chk("R7 random readback", d, exp_read(idx));
      end
    end

    // R9/R12: second instance, no readback, unpipelined
    sel = 1;
    do_read(0, d);
    chk("R9 scalar in reads zero", d, 32'h0);
    do_write(0, 32'hCAFE_F00D, 4'hF, 0);
    chk("R9 scalar in still drives output", b_sin[31:0], 32'hCAFE_F00D);
    do_read(0, d);
    chk("R9 scalar in reads zero after write", d, 32'h0);
    do_write(3, 32'h0000_7777, 4'hF, 2);
    do_write(5, 32'h1, 4'h1, 0);
    chk("R9 vector committed on output", b_vin[63:32], 32'h0000_7777);
    do_read(3, d);
    chk("R9 vector in reads zero", d, 32'h0);
    do_read(7, d);
    chk("R12 snapshot init through unpipelined path", d, 32'h0000_00A1);

    done = 1;
    finish_run();
  end

endmodule